// File: doc/BRIEF.md
# TLB Access Protection Checker

This block sits after the TLB lookup in a processor's memory pipeline. Each cycle it may receive one translated access: an instruction fetch, a load, a store, or a cache-line operation that behaves as a store. With it come the protection fields of the TLB entry that matched: an owner tag, an execute-allowed bit, a write-allowed bit and a 4-bit zone number. The block also sees the current 8-bit process identifier, a 32-bit zone override register, the privilege mode and the two translation enables.

For loads and stores, the block decides in one registered step whether the access is allowed or raises a precise data storage fault. Fetches from a page that may not be executed do not fault at once. Instead, the fetched word is marked with an error tag that travels with it down the pipe. The fault is raised only when the execute stage presents that tagged word for execution and it has not been flushed.

The zone override register holds a 2-bit policy per zone. Rewriting that register changes the protection of every page in a zone at once. An entry whose owner tag is zero belongs to every process.

Top module: `tlb_prot_chk`

## Requirements
- R1: While reset is held and in the first cycle after it, `fault`, `fault_cause`, `tag_valid`, `tag_err` and `miss` are all 0.
- R2: With the relevant translation enabled, an entry applies when `ent_tid` is 0 or equals `pid`. Otherwise, one cycle later `miss` pulses to 1, no fault is raised and `tag_valid` stays 0.
- R3: One cycle after an applicable fetch, `tag_valid` is 1. `tag_err` is 1 exactly when the effective execute permission is 0, and the fetch itself never raises `fault`.
- R4: When `exec_valid` and `exec_tag` are 1 and `exec_flush` is 0, the next cycle shows `fault`=1 with `fault_cause`=1 (fetch-exec). A flushed or untagged word raises nothing.
- R5: A load on an applicable entry is permitted unless the zone denies read. In that case `fault`=1 and `fault_cause`=3 (zone-read) one cycle later.
- R6: A store (`acc_kind`=2) or store-like cache op (`acc_kind`=3) whose effective write permission is 0 gives `fault`=1 and `fault_cause`=2 one cycle later. A zone read denial takes precedence and reports cause 3. A load uses `acc_kind`=1 and a fetch uses `acc_kind`=0.
- R7: Zone n takes its policy from `zpr[31-2n:30-2n]`, where `user_mode`=1 means user. The policy values are:
  - 00: user mode has no access (read, write, execute all denied); supervisor mode uses the entry's EX/WR bits.
  - 01: the entry's bits apply in both modes.
  - 10: supervisor mode has full access; user mode uses the entry's bits.
  - 11: full access in both modes.
- R8: When `itrans_en`=0, fetches give `tag_valid`=1, `tag_err`=0 and no miss. When `dtrans_en`=0, loads and stores give neither a fault nor a miss.
- R9: If an execute-stage fault and a data fault arise in the same cycle, `fault_cause` reports 1.
- R10: `fault` and `miss` are single-cycle pulses. With neither `acc_valid` nor `exec_valid` asserted, the next cycle shows `fault`=0, `miss`=0 and `tag_valid`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pid | input | 8 | Current process identifier (low byte of the process ID register) |
| zpr | input | 32 | Zone override register, zone 0 in bits 31:30 |
| user_mode | input | 1 | 1 = user, 0 = supervisor |
| itrans_en | input | 1 | Instruction translation enabled |
| dtrans_en | input | 1 | Data translation enabled |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 store-like cache op |
| ent_tid | input | 8 | Owner tag of the matched entry |
| ent_ex | input | 1 | Entry execute permission |
| ent_wr | input | 1 | Entry write permission |
| ent_zsel | input | 4 | Entry zone number |
| exec_valid | input | 1 | Execute stage attempts a fetched word |
| exec_tag | input | 1 | Error tag carried by that word |
| exec_flush | input | 1 | That word is discarded instead of executed |
| fault | output | 1 | Registered storage fault pulse |
| fault_cause | output | 2 | 0 none, 1 fetch-exec, 2 store-write, 3 zone-read |
| tag_valid | output | 1 | A fetch result is presented |
| tag_err | output | 1 | Error tag for the fetched word |
| miss | output | 1 | Entry owner tag did not apply |

## Verification
The main patterns form a full sweep: all four zone policies, each combined with all EX/WR pairs, both privilege modes, all four access kinds, and three owner-tag cases (zero, equal to the process ID, different from it). The zone number changes across the sweep, and the other zone fields hold a different policy, so reading the wrong field shows up as a wrong result. Owner tag zero against a non-matching process ID separates the shared-page rule from a plain equality match. Store against load under policy 00 in user mode shows whether read denial takes precedence over write denial. Executed, flushed and untagged words at the execute port show whether a fetch fault is deferred and dropped correctly. A cycle with both an execute fault and a store fault shows whether the cause priority is honoured.

// File: rtl/tlb_prot_pkg.sv
package tlb_prot_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH  = 2'd0,
        ACC_LOAD   = 2'd1,
        ACC_STORE  = 2'd2,
        ACC_CSTORE = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_EXEC  = 2'd1,
        CAUSE_WRITE = 2'd2,
        CAUSE_READ  = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        ZONE_USER_NONE = 2'b00,
        ZONE_ENTRY     = 2'b01,
        ZONE_SUP_FULL  = 2'b10,
        ZONE_ALL_FULL  = 2'b11
    } zone_pol_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    typedef struct packed {
        logic   fault;
        cause_e cause;
        logic   tag_vld;
        logic   tag_err;
        logic   miss;
    } chk_state_t;

endpackage

// File: rtl/tlb_pid_match.sv
module tlb_pid_match #(
    parameter int PID_W = 8
) (
    input  logic [PID_W-1:0] ent_tid,
    input  logic [PID_W-1:0] pid,
    output logic             applies
);
    localparam logic [PID_W-1:0] SHARED_TID = '0;

    always_comb begin
        applies = (ent_tid == SHARED_TID) || (ent_tid == pid);
    end
endmodule

// File: rtl/tlb_zone_perm.sv
module tlb_zone_perm
    import tlb_prot_pkg::*;
#(
    parameter int ZSEL_W = 4
) (
    input  logic [(2<<ZSEL_W)-1:0] zpr,
    input  logic [ZSEL_W-1:0]      zsel,
    input  logic                   user_mode,
    input  logic                   ent_ex,
    input  logic                   ent_wr,
    output perm_t                  perm
);
    localparam int NZONES = 1 << ZSEL_W;
    localparam int ZPR_W  = 2 * NZONES;

    logic [1:0] fields [NZONES];
    zone_pol_e  pol;

    for (genvar z = 0; z < NZONES; z++) begin : g_field
        assign fields[z] = zpr[ZPR_W-1-2*z -: 2];
    end

    always_comb begin
        pol = zone_pol_e'(fields[zsel]);
        perm.rd = 1'b1;
        perm.wr = ent_wr;
        perm.ex = ent_ex;
        unique case (pol)
            ZONE_USER_NONE: begin
                if (user_mode) begin
                    perm.rd = 1'b0;
                    perm.wr = 1'b0;
                    perm.ex = 1'b0;
                end
            end
            ZONE_ENTRY: ;
            ZONE_SUP_FULL: begin
                if (!user_mode) begin
                    perm.wr = 1'b1;
                    perm.ex = 1'b1;
                end
            end
            ZONE_ALL_FULL: begin
                perm.wr = 1'b1;
                perm.ex = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tlb_prot_chk.sv
module tlb_prot_chk
    import tlb_prot_pkg::*;
#(
    parameter int PID_W  = 8,
    parameter int ZSEL_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PID_W-1:0]       pid,
    input  logic [(2<<ZSEL_W)-1:0] zpr,
    input  logic                   user_mode,
    input  logic                   itrans_en,
    input  logic                   dtrans_en,
    input  logic                   acc_valid,
    input  logic [1:0]             acc_kind,
    input  logic [PID_W-1:0]       ent_tid,
    input  logic                   ent_ex,
    input  logic                   ent_wr,
    input  logic [ZSEL_W-1:0]      ent_zsel,
    input  logic                   exec_valid,
    input  logic                   exec_tag,
    input  logic                   exec_flush,
    output logic                   fault,
    output logic [1:0]             fault_cause,
    output logic                   tag_valid,
    output logic                   tag_err,
    output logic                   miss
);
    localparam int ZPR_W = 2 << ZSEL_W;

    acc_kind_e  kind;
    logic       applies;
    perm_t      perm;
    logic       fetch_acc;
    logic       data_acc;
    logic       is_write;
    logic       exec_fault;
    chk_state_t st_d;
    chk_state_t st_q;

    tlb_pid_match #(.PID_W(PID_W)) u_pid_match (
        .ent_tid (ent_tid),
        .pid     (pid),
        .applies (applies)
    );

    tlb_zone_perm #(.ZSEL_W(ZSEL_W)) u_zone_perm (
        .zpr       (zpr),
        .zsel      (ent_zsel),
        .user_mode (user_mode),
        .ent_ex    (ent_ex),
        .ent_wr    (ent_wr),
        .perm      (perm)
    );

    always_comb begin
        kind       = acc_kind_e'(acc_kind);
        fetch_acc  = acc_valid && (kind == ACC_FETCH);
        data_acc   = acc_valid && (kind != ACC_FETCH);
        is_write   = (kind == ACC_STORE) || (kind == ACC_CSTORE);
        exec_fault = exec_valid && exec_tag && !exec_flush;

        st_d = '0;
        // fetch side: tag, never fault here
        if (fetch_acc) begin
            st_d.tag_vld = 1'b1;
            if (itrans_en) begin
                if (!applies) begin
                    st_d.miss    = 1'b1;
                    st_d.tag_vld = 1'b0;
                end else begin
                    st_d.tag_err = !perm.ex;
                end
            end
        end
        // data side: read denial first, then write permission
        if (data_acc && dtrans_en) begin
            if (!applies) begin
                st_d.miss = 1'b1;
            end else if (!perm.rd) begin
                st_d.fault = 1'b1;
                st_d.cause = CAUSE_READ;
            end else if (is_write && !perm.wr) begin
                st_d.fault = 1'b1;
                st_d.cause = CAUSE_WRITE;
            end
        end
        // execute stage: older instruction wins the cause
        if (exec_fault) begin
            st_d.fault = 1'b1;
            st_d.cause = CAUSE_EXEC;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault       = st_q.fault;
    assign fault_cause = st_q.cause;
    assign tag_valid   = st_q.tag_vld;
    assign tag_err     = st_q.tag_err;
    assign miss        = st_q.miss;

    // ---------------- assertions ----------------
    logic [1:0] zfld_chk;
    assign zfld_chk = 2'((zpr >> (ZPR_W - 2 - 2 * int'(ent_zsel))) & ZPR_W'(3));

    AST_EXEC_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_tag && !exec_flush) |=> (fault && fault_cause == 2'd1)); // R4

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_flush && !(acc_valid && acc_kind != 2'd0)) |=> !fault); // R4

    AST_TAG_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 2'd0 && !exec_valid) |=> !fault); // R3

    AST_DATA_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind != 2'd0 && !dtrans_en && !exec_valid) |=> (!fault && !miss)); // R8

    AST_ZONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind != 2'd0 && zfld_chk == 2'b11 && !exec_valid) |=> !fault); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !exec_valid) |=> (!fault && !miss && !tag_valid)); // R10

    AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tag_err |-> tag_valid); // R3
endmodule

// File: tb/tlb_prot_chk_bench.sv
module tlb_prot_chk_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  pid;
    logic [31:0] zpr;
    logic        user_mode, itrans_en, dtrans_en, acc_valid;
    logic [1:0]  acc_kind;
    logic [7:0]  ent_tid;
    logic        ent_ex, ent_wr;
    logic [3:0]  ent_zsel;
    logic        exec_valid, exec_tag, exec_flush;
    logic        fault, tag_valid, tag_err, miss;
    logic [1:0]  fault_cause;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic       fault;
        logic [1:0] cause;
        logic       tv;
        logic       te;
        logic       miss;
        string      req;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_prot_chk u_tlb_prot_chk (
        .clk(clk), .rst_n(rst_n), .pid(pid), .zpr(zpr), .user_mode(user_mode),
        .itrans_en(itrans_en), .dtrans_en(dtrans_en), .acc_valid(acc_valid),
        .acc_kind(acc_kind), .ent_tid(ent_tid), .ent_ex(ent_ex), .ent_wr(ent_wr),
        .ent_zsel(ent_zsel), .exec_valid(exec_valid), .exec_tag(exec_tag),
        .exec_flush(exec_flush), .fault(fault), .fault_cause(fault_cause),
        .tag_valid(tag_valid), .tag_err(tag_err), .miss(miss)
    );

    // expected result of the current inputs, from the requirement text
    function automatic exp_t model(string req);
        exp_t e;
        logic [1:0] pol;
        logic rd, wr, ex, hit;
        e = '{fault: 0, cause: 0, tv: 0, te: 0, miss: 0, req: req};
        pol = zpr[31 - 2*ent_zsel -: 2];
        rd = 1; wr = ent_wr; ex = ent_ex;
        if (pol == 2'b00 && user_mode) begin rd = 0; wr = 0; ex = 0; end
        if (pol == 2'b10 && !user_mode) begin wr = 1; ex = 1; end
        if (pol == 2'b11) begin wr = 1; ex = 1; end
        hit = (ent_tid == 8'h00) || (ent_tid == pid);
        if (acc_valid && acc_kind == 2'd0) begin
            if (!itrans_en) e.tv = 1;
            else if (!hit) e.miss = 1;
            else begin e.tv = 1; e.te = !ex; end
        end
        if (acc_valid && acc_kind != 2'd0 && dtrans_en) begin
            if (!hit) e.miss = 1;
            else if (!rd) begin e.fault = 1; e.cause = 2'd3; end
            else if (acc_kind >= 2'd2 && !wr) begin e.fault = 1; e.cause = 2'd2; end
        end
        if (exec_valid && exec_tag && !exec_flush) begin e.fault = 1; e.cause = 2'd1; end
        return e;
    endfunction

    // driver: inputs already set by caller; push expectation and advance
    task automatic step(string req);
        sb.push_back(model(req));
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        acc_valid = 0; exec_valid = 0; exec_tag = 0; exec_flush = 0;
    endtask

    // monitor: compare one cycle after each driven cycle
    always @(posedge clk) begin
        #1;
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (fault !== e.fault || fault_cause !== e.cause || tag_valid !== e.tv ||
                tag_err !== e.te || miss !== e.miss) begin
                errors++;
                $display("FAIL %s: got f=%b c=%0d tv=%b te=%b m=%b exp f=%b c=%0d tv=%b te=%b m=%b",
                         e.req, fault, fault_cause, tag_valid, tag_err, miss,
                         e.fault, e.cause, e.tv, e.te, e.miss);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        rst_n = 0; pid = 8'h3C; zpr = '0; user_mode = 0; itrans_en = 1; dtrans_en = 1;
        acc_kind = 0; ent_tid = 0; ent_ex = 0; ent_wr = 0; ent_zsel = 0;
        idle_inputs();
        acc_valid = 1; exec_valid = 1; exec_tag = 1; // activity must not leak through reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++; // R1 reset state
        if ({fault, fault_cause, tag_valid, tag_err, miss} !== 6'b0) begin
            errors++;
            $display("FAIL R1: got %b exp 000000", {fault, fault_cause, tag_valid, tag_err, miss});
        end
        idle_inputs();
        rst_n = 1;
        step("R1");

        // main sweep: policy x EX/WR x mode x kind x owner tag
        for (int zv = 0; zv < 4; zv++)
        for (int xw = 0; xw < 4; xw++)
        for (int um = 0; um < 2; um++)
        for (int k = 0; k < 4; k++)
        for (int tc = 0; tc < 3; tc++) begin
            logic [3:0] zs;
            string r;
            zs = 4'((zv * 5 + xw * 3 + um * 7 + k + tc * 2) % 16);
            pid = 8'((8'h3C + 8'(xw)) ^ 8'(tc << 6));
            zpr = '0;
            for (int z = 0; z < 16; z++)
                zpr[31 - 2*z -: 2] = (z == int'(zs)) ? 2'(zv) : ~2'(zv);
            ent_zsel = zs; ent_ex = xw[1]; ent_wr = xw[0]; user_mode = um[0];
            acc_kind = 2'(k); acc_valid = 1;
            ent_tid = (tc == 0) ? 8'h00 : (tc == 1) ? pid : (pid ^ 8'h5A);
            if (tc == 2) r = "R2";
            else if (zv != 1) r = "R7";
            else if (k == 0) r = "R3";
            else if (k == 1) r = "R5";
            else r = "R6";
            step(r);
        end

        // zone read denial against store: read wins (R6, R5)
        zpr = '0; ent_zsel = 4'd9; user_mode = 1; ent_tid = 0; ent_ex = 1; ent_wr = 1;
        acc_valid = 1; acc_kind = 2'd3; step("R6");
        acc_kind = 2'd1; step("R5");

        // translation disabled bypass (R8)
        itrans_en = 0; dtrans_en = 0; ent_tid = 8'hA5; pid = 8'h11;
        acc_kind = 2'd0; step("R8");
        acc_kind = 2'd2; step("R8");
        acc_kind = 2'd1; step("R8");
        itrans_en = 1; dtrans_en = 1;

        // deferred execute fault (R4)
        acc_valid = 0;
        exec_valid = 1; exec_tag = 1; exec_flush = 0; step("R4");
        exec_flush = 1; step("R4");
        exec_flush = 0; exec_tag = 0; step("R4");
        exec_tag = 1; step("R4");
        // pulse ends when idle (R10)
        idle_inputs(); step("R10");
        step("R10");

        // priority: execute fault and store fault together (R9)
        zpr = 32'h5555_5555; ent_zsel = 4'd2; user_mode = 0; ent_tid = 0; ent_wr = 0; ent_ex = 0;
        acc_valid = 1; acc_kind = 2'd2; exec_valid = 1; exec_tag = 1; exec_flush = 0;
        step("R9");
        exec_flush = 1; step("R9");
        idle_inputs(); step("R10");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule